// File: doc/BRIEF.md
# Split-Bank Memory Access Splitter

This block sits between a requester that issues byte or word accesses with a 20-bit byte address and a 16-bit memory built from two byte-wide banks. The low bank holds even addresses and is enabled by address bit 0 being low. The high bank holds odd addresses and is enabled by an active-low high-bank enable. For each access the block decides how many memory transfers are needed, one or two. For each transfer it drives the address, the high-bank enable, the write flag and the write data on the correct byte lane. Read bytes are gathered into one right-justified, little-endian result, and a one-cycle response pulse marks the end of the access.

A mode input selects a narrow 8-bit memory instead. In that mode every byte travels on data bits 7:0, and a word always takes two transfers whatever its alignment. The mode is sampled when a request is accepted.

The request side is valid/ready. A requester holds `req_valid` and its fields steady until it sees `req_ready` high at a rising edge. `req_ready` is high only while the block is idle, so one access is in flight at a time. The response carries no back-pressure: `rsp_valid` pulses for one cycle and the requester must take `rsp_rdata` in that cycle. The memory side uses a request/acknowledge pair. The block holds `mem_req` and every transfer field steady until the memory raises `mem_ack`. A transfer completes at the rising edge where both are high.

Top module: `bank_access_splitter`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_req` is 0 and `rsp_valid` is 0.
- R2: A request is accepted at a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from the cycle after acceptance until the response cycle. While `mem_req` is 1 and `mem_ack` is 0, the values of `mem_addr`, `mem_we`, `mem_bhe_n` and `mem_wdata` hold into the next cycle.
- R3: In 16-bit mode, a byte at an even address takes one transfer at that address with `mem_bhe_n`=1. A write puts the byte on both halves of `mem_wdata`. A read returns {8'h00, `mem_rdata`[7:0]}.
- R4: In 16-bit mode, a byte at an odd address takes one transfer at that address with `mem_bhe_n`=0. A read returns {8'h00, `mem_rdata`[15:8]}, right-justified. A write puts the byte on both halves of `mem_wdata`.
- R5: In 16-bit mode, a word at an even address takes one transfer with `mem_bhe_n`=0 and `mem_wdata` equal to the full write word. A read returns `mem_rdata` unchanged.
- R6: In 16-bit mode, a word at an odd address A takes two transfers. The first is at A with `mem_bhe_n`=0 and data {w[7:0],w[7:0]}. The second is at A+1 with `mem_bhe_n`=1 and data {w[15:8],w[15:8]}. A read returns {second `mem_rdata`[7:0], first `mem_rdata`[15:8]}, so the byte from A is the low byte.
- R7: In 8-bit mode (`narrow_mode`=1), every transfer has `mem_bhe_n`=1 and reads use only `mem_rdata`[7:0]. A byte takes one transfer. A word at any address takes two transfers: A carrying w[7:0], then A+1 carrying w[15:8]. Each write byte appears on both halves of `mem_wdata`.
- R8: The address of a second transfer is the first address plus one, modulo 2^20, so FFFFF is followed by 00000.
- R9: `rsp_valid` is 1 for exactly one cycle, the cycle after the edge that completes the last transfer. `rsp_rdata` is valid in that cycle and is 0 for writes.
- R10: `narrow_mode` is sampled at acceptance. A change while an access is in flight does not alter that access's transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| narrow_mode | input | 1 | 1 selects the 8-bit memory, 0 the two-bank 16-bit memory |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request will be taken |
| req_write | input | 1 | 1 write, 0 read |
| req_word | input | 1 | 1 word access, 0 byte access |
| req_addr | input | 20 | Byte address of the access |
| req_wdata | input | 16 | Write data, byte in bits 7:0 for byte writes |
| mem_req | output | 1 | Transfer requested, held until acknowledged |
| mem_ack | input | 1 | Memory acknowledges the current transfer |
| mem_addr | output | 20 | Transfer byte address, bit 0 enables the low bank when 0 |
| mem_we | output | 1 | Transfer is a write |
| mem_bhe_n | output | 1 | High-bank enable, active low |
| mem_wdata | output | 16 | Write data steered onto the byte lanes |
| mem_rdata | input | 16 | Read data from the memory, valid with mem_ack |
| rsp_valid | output | 1 | One-cycle end-of-access pulse |
| rsp_rdata | output | 16 | Assembled read data, valid with rsp_valid |

## Verification
The first transfer appears on `mem_req` one cycle after the acceptance edge. The next cycle `mem_ack` can arrive from a zero-wait memory model at the earliest. A second transfer appears in the cycle after the first completes. `rsp_valid` rises in the cycle after the final completion edge, and `req_ready` returns in that same cycle. The bench drives and samples at falling edges. It waits on the handshake events themselves rather than fixed delays, and checks the fixed offsets explicitly: `req_ready` low one cycle after acceptance, and `rsp_valid` gone one cycle after it appears. The memory model records each completed transfer, so lane, enable and address checks read that log once the response has arrived.

// File: rtl/bas_pkg.sv
package bas_pkg;
  typedef enum logic [1:0] {
    LANE_LO   = 2'd0,
    LANE_HI   = 2'd1,
    LANE_BOTH = 2'd2
  } lane_e;

  typedef struct packed {
    logic  two;
    lane_e lane0;
    lane_e lane1;
  } plan_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_XFER = 1'b1
  } seq_state_e;
endpackage

// File: rtl/bas_lane_planner.sv
module bas_lane_planner
  import bas_pkg::*;
(
  input  logic  is_word,
  input  logic  addr_lsb,
  input  logic  narrow,
  output plan_t plan
);
  always_comb begin
    plan.two   = 1'b0;
    plan.lane0 = LANE_LO;
    plan.lane1 = LANE_LO;
    if (narrow) begin
      plan.two = is_word;
    end else if (is_word) begin
      if (addr_lsb) begin
        plan.two   = 1'b1;
        plan.lane0 = LANE_HI;
      end else begin
        plan.lane0 = LANE_BOTH;
      end
    end else begin
      plan.lane0 = addr_lsb ? LANE_HI : LANE_LO;
    end
  end
endmodule

// File: rtl/bas_lane_driver.sv
module bas_lane_driver
  import bas_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  lane_e                  lane,
  input  logic                   second,
  input  logic [2*BYTE_W-1:0]    wdata,
  output logic                   bhe_n,
  output logic [2*BYTE_W-1:0]    lane_wdata
);
  localparam int DATA_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] sel_byte;
  logic [DATA_W-1:0] spread;

  assign sel_byte = second ? wdata[DATA_W-1:BYTE_W] : wdata[BYTE_W-1:0];

  for (genvar g = 0; g < 2; g++) begin : g_spread
    assign spread[g*BYTE_W +: BYTE_W] = sel_byte;
  end

  assign bhe_n      = (lane == LANE_LO);
  assign lane_wdata = (lane == LANE_BOTH) ? wdata : spread;
endmodule

// File: rtl/bas_read_merge.sv
module bas_read_merge
  import bas_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                capture,
  input  logic                is_read,
  input  lane_e               lane,
  input  logic                second,
  input  logic [2*BYTE_W-1:0] rdata,
  output logic [2*BYTE_W-1:0] acc
);
  localparam int DATA_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] src_byte;

  assign src_byte = (lane == LANE_HI) ? rdata[DATA_W-1:BYTE_W] : rdata[BYTE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (clear) begin
      acc <= '0;
    end else if (capture && is_read) begin
      if (lane == LANE_BOTH) begin
        acc <= rdata;
      end else if (second) begin
        acc[DATA_W-1:BYTE_W] <= src_byte;
      end else begin
        acc[BYTE_W-1:0] <= src_byte;
      end
    end
  end

  // R5: a full-width lane only ever occurs as a single, first transfer
  a_r5_word_single: assert property (@(posedge clk) disable iff (!rst_n)
    capture && (lane == LANE_BOTH) |-> !second);
endmodule

// File: rtl/bas_sequencer.sv
module bas_sequencer
  import bas_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              narrow_mode,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  plan_t             plan_in,
  input  logic              mem_ack,
  output logic              req_ready,
  output logic              accept,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output lane_e             cur_lane,
  output logic              second,
  output logic [DATA_W-1:0] wdata_q,
  output logic              narrow_q,
  output logic              rsp_valid
);
  seq_state_e        state;
  plan_t             plan_q;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign mem_req   = (state == ST_XFER);
  assign mem_addr  = addr_q;
  assign mem_we    = we_q;
  assign cur_lane  = second ? plan_q.lane1 : plan_q.lane0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      plan_q    <= '0;
      addr_q    <= '0;
      we_q      <= 1'b0;
      wdata_q   <= '0;
      narrow_q  <= 1'b0;
      second    <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            plan_q   <= plan_in;
            addr_q   <= req_addr;
            we_q     <= req_write;
            wdata_q  <= req_wdata;
            narrow_q <= narrow_mode;
            second   <= 1'b0;
            state    <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (mem_ack) begin
            if (!second && plan_q.two) begin
              second <= 1'b1;
              addr_q <= addr_q + 1'b1;
            end else begin
              state     <= ST_IDLE;
              rsp_valid <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: the end-of-access pulse never lasts two cycles
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R2: no transfer is requested while a request could be taken
  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);
endmodule

// File: rtl/bank_access_splitter.sv
module bank_access_splitter
  import bas_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                narrow_mode,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic                req_word,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [2*BYTE_W-1:0] req_wdata,
  output logic                mem_req,
  input  logic                mem_ack,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_we,
  output logic                mem_bhe_n,
  output logic [2*BYTE_W-1:0] mem_wdata,
  input  logic [2*BYTE_W-1:0] mem_rdata,
  output logic                rsp_valid,
  output logic [2*BYTE_W-1:0] rsp_rdata
);
  localparam int DATA_W = 2 * BYTE_W;

  plan_t             plan_req;
  lane_e             cur_lane;
  logic              accept;
  logic              second;
  logic              narrow_q;
  logic [DATA_W-1:0] wdata_q;

  bas_lane_planner u_planner (
    .is_word  (req_word),
    .addr_lsb (req_addr[0]),
    .narrow   (narrow_mode),
    .plan     (plan_req)
  );

  bas_sequencer #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .narrow_mode (narrow_mode),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .plan_in     (plan_req),
    .mem_ack     (mem_ack),
    .req_ready   (req_ready),
    .accept      (accept),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_we      (mem_we),
    .cur_lane    (cur_lane),
    .second      (second),
    .wdata_q     (wdata_q),
    .narrow_q    (narrow_q),
    .rsp_valid   (rsp_valid)
  );

  bas_lane_driver #(
    .BYTE_W (BYTE_W)
  ) u_drv (
    .lane       (cur_lane),
    .second     (second),
    .wdata      (wdata_q),
    .bhe_n      (mem_bhe_n),
    .lane_wdata (mem_wdata)
  );

  bas_read_merge #(
    .BYTE_W (BYTE_W)
  ) u_merge (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .capture (mem_req && mem_ack),
    .is_read (!mem_we),
    .lane    (cur_lane),
    .second  (second),
    .rdata   (mem_rdata),
    .acc     (rsp_rdata)
  );

  // R2: an unacknowledged transfer keeps every field steady
  a_r2_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                            && $stable(mem_bhe_n) && $stable(mem_wdata));

  // R8: a transfer following a completed one sits one byte higher, wrapping
  a_r8_next_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> !mem_req || (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

  // R4: in 16-bit mode an odd address always enables the high bank
  a_r4_odd_high: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !narrow_q && mem_addr[0] |-> !mem_bhe_n);

  // R7: the narrow memory never sees the high-bank enable
  a_r7_narrow_low: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && narrow_q |-> mem_bhe_n);
endmodule

// File: tb/tb_bank_access_splitter.sv
module tb_bank_access_splitter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        narrow_mode = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_word = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        mem_req;
  logic        mem_ack;
  logic [19:0] mem_addr;
  logic        mem_we;
  logic        mem_bhe_n;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;

  int total = 0;
  int bad = 0;
  bit fin = 0;

  always #2 clk = ~clk;

  bank_access_splitter dut (
    .clk(clk), .rst_n(rst_n), .narrow_mode(narrow_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_bhe_n(mem_bhe_n), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  // memory model and transfer log
  logic [7:0]  mem [logic [19:0]];
  logic [19:0] lg_addr [0:255];
  logic        lg_bhe  [0:255];
  logic [15:0] lg_wd   [0:255];
  int          lg_n = 0;
  int          wait_n = 0;
  int          wcnt = 0;
  bit          nb = 0;

  function automatic logic [7:0] rd8(input logic [19:0] a);
    if (mem.exists(a)) return mem[a];
    return a[7:0] ^ 8'hA5;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      wcnt      <= 0;
    end else if (mem_req && mem_ack) begin
      mem_ack <= 1'b0;
      wcnt    <= 0;
      lg_addr[lg_n % 256] <= mem_addr;
      lg_bhe[lg_n % 256]  <= mem_bhe_n;
      lg_wd[lg_n % 256]   <= mem_wdata;
      lg_n <= lg_n + 1;
      if (mem_we) begin
        if (nb) mem[mem_addr] = mem_wdata[7:0];
        else begin
          if (!mem_addr[0]) mem[mem_addr] = mem_wdata[7:0];
          if (!mem_bhe_n) mem[mem_addr | 20'h1] = mem_wdata[15:8];
        end
      end
    end else if (mem_req) begin
      if (wcnt >= wait_n) begin
        mem_ack   <= 1'b1;
        mem_rdata <= nb ? {8'hEE, rd8(mem_addr)}
                        : {rd8(mem_addr | 20'h1), rd8(mem_addr & 20'hFFFFE)};
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  task automatic chk(input string msg, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", msg, act, exp);
    end
  endtask

  task automatic do_req(input logic wr, input logic wd, input logic [19:0] a,
                        input logic [15:0] wdat, input bit flip,
                        output logic [15:0] rdat, output int first);
    int n;
    @(negedge clk);
    req_write = wr; req_word = wd; req_addr = a; req_wdata = wdat; req_valid = 1'b1;
    n = 0;
    while (!req_ready && n < 100) begin @(negedge clk); n++; end
    first = lg_n;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = ~a;
    req_word  = ~wd;
    if (flip) narrow_mode = ~narrow_mode;
    chk("R2 ready low after accept", {31'd0, req_ready}, 32'd0);
    n = 0;
    while (!rsp_valid && n < 500) begin @(negedge clk); n++; end
    chk("R9 response arrives", {31'd0, rsp_valid}, 32'd1);
    rdat = rsp_rdata;
    @(negedge clk);
    chk("R9 response lasts one cycle", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 ready after reset", {31'd0, req_ready}, 32'd1);
    chk("R1 no transfer after reset", {31'd0, mem_req}, 32'd0);
    chk("R1 no response after reset", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic t_byte_even;
    logic [15:0] r; int f; logic [7:0] nb_keep;
    nb = 0; narrow_mode = 0;
    do_req(0, 0, 20'h12344, 16'h0, 0, r, f);
    chk("R3 even byte one transfer", lg_n - f, 1);
    chk("R3 even byte addr", {12'd0, lg_addr[f]}, 32'h12344);
    chk("R3 even byte bhe_n high", {31'd0, lg_bhe[f]}, 32'd1);
    chk("R3 even byte read", {16'd0, r}, {24'd0, rd8(20'h12344)});
    nb_keep = rd8(20'h12345);
    do_req(1, 0, 20'h12344, 16'h55C3, 0, r, f);
    chk("R3 even byte write lanes", {16'd0, lg_wd[f]}, 32'hC3C3);
    chk("R9 write returns zero", {16'd0, r}, 32'd0);
    chk("R3 even byte written", {24'd0, rd8(20'h12344)}, 32'hC3);
    chk("R3 neighbour untouched", {24'd0, rd8(20'h12345)}, {24'd0, nb_keep});
  endtask

  task automatic t_byte_odd;
    logic [15:0] r; int f; logic [7:0] ev;
    nb = 0; narrow_mode = 0;
    do_req(0, 0, 20'h23457, 16'h0, 0, r, f);
    chk("R4 odd byte one transfer", lg_n - f, 1);
    chk("R4 odd byte bhe_n low", {31'd0, lg_bhe[f]}, 32'd0);
    chk("R4 odd byte right-justified", {16'd0, r}, {24'd0, rd8(20'h23457)});
    ev = rd8(20'h23456);
    do_req(1, 0, 20'h23457, 16'hAA77, 0, r, f);
    chk("R4 odd byte write lanes", {16'd0, lg_wd[f]}, 32'h7777);
    chk("R4 odd byte written", {24'd0, rd8(20'h23457)}, 32'h77);
    chk("R4 even neighbour untouched", {24'd0, rd8(20'h23456)}, {24'd0, ev});
  endtask

  task automatic t_word_even;
    logic [15:0] r; int f;
    nb = 0; narrow_mode = 0;
    do_req(0, 1, 20'h00400, 16'h0, 0, r, f);
    chk("R5 even word one transfer", lg_n - f, 1);
    chk("R5 even word bhe_n low", {31'd0, lg_bhe[f]}, 32'd0);
    chk("R5 even word read", {16'd0, r}, {16'd0, rd8(20'h00401), rd8(20'h00400)});
    do_req(1, 1, 20'h00400, 16'hBEEF, 0, r, f);
    chk("R5 even word write data", {16'd0, lg_wd[f]}, 32'hBEEF);
    do_req(0, 1, 20'h00400, 16'h0, 0, r, f);
    chk("R5 even word read back", {16'd0, r}, 32'hBEEF);
  endtask

  task automatic t_word_odd;
    logic [15:0] r; int f;
    nb = 0; narrow_mode = 0;
    do_req(0, 1, 20'h00101, 16'h0, 0, r, f);
    chk("R6 odd word two transfers", lg_n - f, 2);
    chk("R6 first addr", {12'd0, lg_addr[f]}, 32'h00101);
    chk("R6 first bhe_n low", {31'd0, lg_bhe[f]}, 32'd0);
    chk("R6 second addr", {12'd0, lg_addr[f+1]}, 32'h00102);
    chk("R6 second bhe_n high", {31'd0, lg_bhe[f+1]}, 32'd1);
    chk("R6 odd word assembled", {16'd0, r}, {16'd0, rd8(20'h00102), rd8(20'h00101)});
    do_req(1, 1, 20'h00201, 16'h1234, 0, r, f);
    chk("R6 first write lanes", {16'd0, lg_wd[f]}, 32'h3434);
    chk("R6 second write lanes", {16'd0, lg_wd[f+1]}, 32'h1212);
    do_req(0, 1, 20'h00201, 16'h0, 0, r, f);
    chk("R6 odd word read back", {16'd0, r}, 32'h1234);
    do_req(0, 0, 20'h00201, 16'h0, 0, r, f);
    chk("R6 low byte at lower address", {16'd0, r}, 32'h0034);
  endtask

  task automatic t_narrow;
    logic [15:0] r; int f;
    nb = 1; narrow_mode = 1;
    do_req(0, 1, 20'h00600, 16'h0, 0, r, f);
    chk("R7 narrow even word two transfers", lg_n - f, 2);
    chk("R7 narrow first addr", {12'd0, lg_addr[f]}, 32'h00600);
    chk("R7 narrow second addr", {12'd0, lg_addr[f+1]}, 32'h00601);
    chk("R7 narrow bhe_n high", {30'd0, lg_bhe[f], lg_bhe[f+1]}, 32'd3);
    chk("R7 narrow word read", {16'd0, r}, {16'd0, rd8(20'h00601), rd8(20'h00600)});
    do_req(0, 0, 20'h00603, 16'h0, 0, r, f);
    chk("R7 narrow odd byte one transfer", lg_n - f, 1);
    chk("R7 narrow odd byte bhe_n high", {31'd0, lg_bhe[f]}, 32'd1);
    chk("R7 narrow byte from low lane", {16'd0, r}, {24'd0, rd8(20'h00603)});
    do_req(1, 1, 20'h00605, 16'hABCD, 0, r, f);
    chk("R7 narrow write first", {16'd0, lg_wd[f]}, 32'hCDCD);
    chk("R7 narrow write second", {16'd0, lg_wd[f+1]}, 32'hABAB);
    do_req(0, 1, 20'h00605, 16'h0, 0, r, f);
    chk("R7 narrow read back", {16'd0, r}, 32'hABCD);
  endtask

  task automatic t_wrap;
    logic [15:0] r; int f;
    nb = 0; narrow_mode = 0;
    do_req(0, 1, 20'hFFFFF, 16'h0, 0, r, f);
    chk("R8 wide wrap second addr", {12'd0, lg_addr[f+1]}, 32'h00000);
    chk("R8 wide wrap data", {16'd0, r}, {16'd0, rd8(20'h00000), rd8(20'hFFFFF)});
    nb = 1; narrow_mode = 1;
    do_req(0, 1, 20'hFFFFF, 16'h0, 0, r, f);
    chk("R8 narrow wrap second addr", {12'd0, lg_addr[f+1]}, 32'h00000);
    chk("R8 narrow wrap data", {16'd0, r}, {16'd0, rd8(20'h00000), rd8(20'hFFFFF)});
  endtask

  task automatic t_waits_and_mode;
    logic [15:0] r; int f;
    wait_n = 3;
    nb = 0; narrow_mode = 0;
    do_req(0, 1, 20'h00711, 16'h0, 0, r, f);
    chk("R2 waits odd word two transfers", lg_n - f, 2);
    chk("R2 waits data", {16'd0, r}, {16'd0, rd8(20'h00712), rd8(20'h00711)});
    nb = 1; narrow_mode = 1;
    do_req(0, 1, 20'h00800, 16'h0, 1, r, f);
    chk("R10 mode kept after change", lg_n - f, 2);
    chk("R10 bhe_n stays high", {30'd0, lg_bhe[f], lg_bhe[f+1]}, 32'd3);
    chk("R10 data from low lane", {16'd0, r}, {16'd0, rd8(20'h00801), rd8(20'h00800)});
    wait_n = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte_even();
    t_byte_odd();
    t_word_even();
    t_word_odd();
    t_narrow();
    t_wrap();
    t_waits_and_mode();
    fin = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      total++;
      bad++;
      $display("FAIL watchdog R2 act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule